// File: doc/BRIEF.md
# Extend-Prefix Halfword Decoder

This block sits at the front of a compact-encoding decode stage. It takes one 16-bit instruction halfword per cycle, qualified by a valid strobe. A halfword that carries the extend tag is not an operation. It is stored and then spliced into the next halfword that is accepted. This widens the immediate of a compare-immediate to a full 16 bits, and widens the amount of a shift to 5 bits, or 6 bits for the 64-bit left shift.

For every accepted non-prefix halfword, the block drives a decoded bundle in the same cycle. The bundle holds:
- an operation class;
- an ALU operation code;
- two source register indices and a destination register index, each translated to the full 5-bit register space;
- a flag for writing the compare register;
- the assembled immediate or shift amount.

It also flags a prefix that precedes an instruction which cannot be extended. The outputs are combinational from the halfword input and the held prefix register.

Top module: `xd_top`

## Requirements
- R1: A halfword accepted with bits [15:11] = 11110 is a prefix. In that cycle `op_valid` stays low. Its bits [10:0] are held for the next accepted halfword. While `hw_valid` is low, the held prefix is kept unchanged.
- R2: `op_valid` is high exactly in the cycles where `hw_valid` is high and the halfword is not a prefix, so a prefixed instruction takes two input cycles. Any such halfword consumes the held prefix. While `op_valid` is low, the outputs read class 0, ALU code 15, registers 0, immediate 0, and `wr_cmp` and `illegal` are both low.
- R3: Major opcode [15:11] = 11100 gives class 1. The bits [1:0] select the ALU code: 01 gives add (0), 11 gives subtract (1), 00 gives 64-bit add (2) and 10 gives 64-bit subtract (3). Sources come from fields [10:8] and [7:5], the destination from [4:2], and the immediate is 0.
- R4: Major opcode 11101 gives class 2, selected by bits [4:0]. Three of these codes have both sources from the fields: 01100 gives and (7), 01101 gives or (8) and 01110 gives xor (9), with source A from [10:8], source B from [7:5] and the destination from [10:8]. The other two read register 0 as source A: 01011 gives negate (6) and 01111 gives not (10), with source B from [7:5] and the destination from [10:8]. Any other code gives class 0 with ALU code 15.
- R5: With major 11101, the code 00010 gives set-less-than (4) and 00011 gives unsigned set-less-than (5). Both read sources [10:8] and [7:5], write register 24, and raise `wr_cmp`.
- R6: Major opcode 00110 gives class 3. The bits [1:0] select the ALU code: 00 gives left (11), 10 gives logical right (12), 11 gives arithmetic right (13) and 01 gives 64-bit left (14). The source comes from [7:5] and the destination from [4:2] is not used; the destination comes from [10:8]. Without a prefix, the amount is bits [4:2].
- R7: A prefixed shift takes its amount from prefix bits [10:6]. For the 64-bit left shift only, prefix bit [5] becomes amount bit 5; for the other shifts, amount bit 5 is 0.
- R8: Major opcode 01110 gives class 4 with ALU code xor (9). Source A comes from [10:8]. The destination is register 24, and `wr_cmp` is high. Without a prefix, the immediate is bits [7:0], zero-extended. With a prefix, the immediate is {prefix[4:0], prefix[10:5], halfword[4:0]}.
- R9: Every 3-bit register field is translated before output: 0 becomes 16, 1 becomes 17, and 2 to 7 keep their value.
- R10: A prefix followed by a halfword whose class is not 3 or 4 raises `illegal`. In that case the other outputs read as in the idle state of R2. Without a prefix, an unknown opcode gives class 0 and does not raise `illegal`.
- R11: A prefix that follows a held prefix replaces it. Reset discards any held prefix.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| hw_valid | input | 1 | Halfword strobe |
| hw_data | input | 16 | Instruction halfword |
| op_valid | output | 1 | Decoded bundle valid |
| op_class | output | 3 | Operation class |
| alu_op | output | 4 | ALU operation code |
| src_a | output | 5 | First source register index |
| src_b | output | 5 | Second source register index |
| dst | output | 5 | Destination register index |
| wr_cmp | output | 1 | Result goes to the compare register |
| imm | output | 16 | Assembled immediate or shift amount |
| illegal | output | 1 | Prefix placed before a non-extendable opcode |

## Verification
The bench feeds short directed sequences of halfwords:
- plain halfwords of every format, which tell apart the function-field decodes and the register translation;
- prefix-then-instruction pairs, which separate the extended fields from the short ones, including the sixth shift bit that only the 64-bit left shift may use;
- prefix-prefix chains and prefixes followed by gaps in `hw_valid`, or by reset, which show whether the held state is replaced, kept or dropped.

A long biased random stream then mixes prefixes, the four formats and unknown opcodes. A behavioural model compares the whole bundle with that model's own expectation in every cycle.

// File: rtl/xd_pkg.sv
`timescale 1ns/1ps
package xd_pkg;
  localparam int HW_W  = 16;
  localparam int TAG_W = 5;
  localparam int PAY_W = HW_W - TAG_W;

  localparam logic [TAG_W-1:0] MAJ_PREFIX = 5'b11110;
  localparam logic [TAG_W-1:0] MAJ_RRR    = 5'b11100;
  localparam logic [TAG_W-1:0] MAJ_RR     = 5'b11101;
  localparam logic [TAG_W-1:0] MAJ_SHIFT  = 5'b00110;
  localparam logic [TAG_W-1:0] MAJ_CMPI   = 5'b01110;

  typedef enum logic [2:0] {
    CL_OTHER = 3'd0, CL_RRR = 3'd1, CL_RR = 3'd2, CL_SHIFT = 3'd3, CL_CMPI = 3'd4
  } op_class_e;

  typedef enum logic [3:0] {
    AL_ADD = 4'd0, AL_SUB = 4'd1, AL_DADD = 4'd2, AL_DSUB = 4'd3,
    AL_SLT = 4'd4, AL_SLTU = 4'd5, AL_NEG = 4'd6, AL_AND = 4'd7,
    AL_OR = 4'd8, AL_XOR = 4'd9, AL_NOT = 4'd10, AL_SLL = 4'd11,
    AL_SRL = 4'd12, AL_SRA = 4'd13, AL_DSLL = 4'd14, AL_NOP = 4'd15
  } alu_op_e;

  typedef enum logic [1:0] {
    RS_ZERO = 2'd0, RS_MAP = 2'd1, RS_CMP = 2'd2
  } reg_src_e;
endpackage

// File: rtl/xd_prefix_hold.sv
`timescale 1ns/1ps
module xd_prefix_hold
  import xd_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             in_valid,
  input  logic [HW_W-1:0]  in_data,
  output logic             is_pfx,
  output logic             pfx_vld,
  output logic [PAY_W-1:0] pfx_q
);
  logic             vld_d;
  logic [PAY_W-1:0] pay_d;
  logic             pay_en;

  assign is_pfx = (in_data[HW_W-1 -: TAG_W] == MAJ_PREFIX);
  assign pay_en = in_valid && is_pfx;

  always_comb begin
    vld_d = pfx_vld;
    pay_d = pfx_q;
    if (in_valid) begin
      vld_d = is_pfx;
      if (is_pfx) pay_d = in_data[PAY_W-1:0];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pfx_vld <= 1'b0;
    else        pfx_vld <= vld_d;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pfx_q <= '0;
    else if (pay_en) pfx_q <= pay_d;
  end

  p_prefix_held_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && is_pfx) |=> (pfx_vld && pfx_q == $past(in_data[PAY_W-1:0])));

  p_prefix_consumed_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && !is_pfx) |=> !pfx_vld);

  p_prefix_kept_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(pfx_vld) && $stable(pfx_q)));
endmodule

// File: rtl/xd_reg_map.sv
`timescale 1ns/1ps
module xd_reg_map
  import xd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int CMP_REG = 24
) (
  input  reg_src_e         kind,
  input  logic [2:0]       code,
  output logic [REG_W-1:0] idx
);
  localparam logic [REG_W-1:0] LOW0 = REG_W'(16);
  localparam logic [REG_W-1:0] LOW1 = REG_W'(17);

  always_comb begin
    unique case (kind)
      RS_MAP: begin
        if (code == 3'd0)      idx = LOW0;
        else if (code == 3'd1) idx = LOW1;
        else                   idx = REG_W'(code);
      end
      RS_CMP:  idx = REG_W'(CMP_REG);
      default: idx = '0;
    endcase
  end
endmodule

// File: rtl/xd_field_dec.sv
`timescale 1ns/1ps
module xd_field_dec
  import xd_pkg::*;
(
  input  logic             dec_en,
  input  logic [HW_W-1:0]  hw,
  input  logic             ext,
  input  logic [PAY_W-1:0] pay,
  output op_class_e        cls,
  output alu_op_e          alu,
  output reg_src_e         kind_a,
  output reg_src_e         kind_b,
  output reg_src_e         kind_d,
  output logic [2:0]       code_a,
  output logic [2:0]       code_b,
  output logic [2:0]       code_d,
  output logic             wr_cmp,
  output logic [15:0]      imm,
  output logic             illegal
);
  logic [2:0] f_x, f_y, f_z;
  logic [TAG_W-1:0] major;
  logic [5:0] shamt;

  assign major = hw[HW_W-1 -: TAG_W];
  assign f_x   = hw[10:8];
  assign f_y   = hw[7:5];
  assign f_z   = hw[4:2];

  always_comb begin
    cls = CL_OTHER; alu = AL_NOP; wr_cmp = 1'b0; imm = '0; illegal = 1'b0;
    kind_a = RS_ZERO; kind_b = RS_ZERO; kind_d = RS_ZERO;
    code_a = f_x; code_b = f_y; code_d = f_x;
    shamt = '0;
    if (dec_en) begin
      unique case (major)
        MAJ_RRR: begin
          cls = CL_RRR; kind_a = RS_MAP; kind_b = RS_MAP; kind_d = RS_MAP;
          code_d = f_z;
          unique case (hw[1:0])
            2'b01: alu = AL_ADD;
            2'b11: alu = AL_SUB;
            2'b00: alu = AL_DADD;
            default: alu = AL_DSUB;
          endcase
        end
        MAJ_RR: begin
          cls = CL_RR; kind_a = RS_MAP; kind_b = RS_MAP; kind_d = RS_MAP;
          unique case (hw[4:0])
            5'b00010: begin alu = AL_SLT;  kind_d = RS_CMP; wr_cmp = 1'b1; end
            5'b00011: begin alu = AL_SLTU; kind_d = RS_CMP; wr_cmp = 1'b1; end
            5'b01011: begin alu = AL_NEG; kind_a = RS_ZERO; end
            5'b01100: alu = AL_AND;
            5'b01101: alu = AL_OR;
            5'b01110: alu = AL_XOR;
            5'b01111: begin alu = AL_NOT; kind_a = RS_ZERO; end
            default: begin
              cls = CL_OTHER; kind_a = RS_ZERO; kind_b = RS_ZERO; kind_d = RS_ZERO;
            end
          endcase
        end
        MAJ_SHIFT: begin
          cls = CL_SHIFT; kind_a = RS_MAP; kind_d = RS_MAP;
          code_a = f_y;
          unique case (hw[1:0])
            2'b00: alu = AL_SLL;
            2'b10: alu = AL_SRL;
            2'b11: alu = AL_SRA;
            default: alu = AL_DSLL;
          endcase
          if (ext) shamt = {(hw[1:0] == 2'b01) && pay[5], pay[10:6]};
          else     shamt = {3'b000, f_z};
          imm = {10'd0, shamt};
        end
        MAJ_CMPI: begin
          cls = CL_CMPI; alu = AL_XOR; kind_a = RS_MAP; kind_d = RS_CMP;
          wr_cmp = 1'b1;
          if (ext) imm = {pay[4:0], pay[10:5], hw[4:0]};
          else     imm = {8'd0, hw[7:0]};
        end
        default: ;
      endcase
      if (ext && cls != CL_SHIFT && cls != CL_CMPI) begin
        illegal = 1'b1; cls = CL_OTHER; alu = AL_NOP; wr_cmp = 1'b0; imm = '0;
        kind_a = RS_ZERO; kind_b = RS_ZERO; kind_d = RS_ZERO;
      end
    end
  end
endmodule

// File: rtl/xd_top.sv
`timescale 1ns/1ps
module xd_top
  import xd_pkg::*;
#(
  parameter int REG_W   = 5,
  parameter int CMP_REG = 24
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hw_valid,
  input  logic [15:0]      hw_data,
  output logic             op_valid,
  output logic [2:0]       op_class,
  output logic [3:0]       alu_op,
  output logic [REG_W-1:0] src_a,
  output logic [REG_W-1:0] src_b,
  output logic [REG_W-1:0] dst,
  output logic             wr_cmp,
  output logic [15:0]      imm,
  output logic             illegal
);
  localparam int NPORT = 3;

  logic             is_pfx, pfx_vld;
  logic [PAY_W-1:0] pfx_q;
  op_class_e        cls;
  alu_op_e          alu;
  reg_src_e         kind [NPORT];
  logic [2:0]       code [NPORT];
  logic [REG_W-1:0] idx  [NPORT];

  xd_prefix_hold u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(hw_valid), .in_data(hw_data),
    .is_pfx(is_pfx), .pfx_vld(pfx_vld), .pfx_q(pfx_q)
  );

  assign op_valid = hw_valid && !is_pfx;

  xd_field_dec u_dec (
    .dec_en(op_valid), .hw(hw_data), .ext(pfx_vld), .pay(pfx_q),
    .cls(cls), .alu(alu),
    .kind_a(kind[0]), .kind_b(kind[1]), .kind_d(kind[2]),
    .code_a(code[0]), .code_b(code[1]), .code_d(code[2]),
    .wr_cmp(wr_cmp), .imm(imm), .illegal(illegal)
  );

  for (genvar g = 0; g < NPORT; g++) begin : g_map
    xd_reg_map #(.REG_W(REG_W), .CMP_REG(CMP_REG)) u_map (
      .kind(kind[g]), .code(code[g]), .idx(idx[g])
    );
  end

  assign op_class = cls;
  assign alu_op   = alu;
  assign src_a    = idx[0];
  assign src_b    = idx[1];
  assign dst      = idx[2];

  p_illegal_after_prefix_r10: assert property (@(posedge clk) disable iff (!rst_n)
    illegal |-> (pfx_vld && op_valid));

  p_cmp_dest_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && wr_cmp) |-> (dst == REG_W'(CMP_REG)));

  p_idle_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !op_valid |-> (op_class == 3'd0 && !wr_cmp && !illegal && imm == 16'd0));

  p_ext_imm_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 3'd4 && pfx_vld) |-> (imm[15:11] == pfx_q[4:0]));

  p_ext_shamt_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_valid && op_class == 3'd3 && pfx_vld) |-> (imm[4:0] == pfx_q[10:6]));
endmodule

// File: tb/sim_xd_top.sv
`timescale 1ns/1ps
module sim_xd_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        hw_valid = 1'b0;
  logic [15:0] hw_data = 16'd0;
  logic        op_valid, wr_cmp, illegal;
  logic [2:0]  op_class;
  logic [3:0]  alu_op;
  logic [4:0]  src_a, src_b, dst;
  logic [15:0] imm;

  int n_run = 0;
  int n_fail = 0;
  bit done = 0;

  bit        m_pv = 0;
  bit [10:0] m_pay = '0;

  always #2 clk = ~clk;

  xd_top u0 (
    .clk(clk), .rst_n(rst_n), .hw_valid(hw_valid), .hw_data(hw_data),
    .op_valid(op_valid), .op_class(op_class), .alu_op(alu_op),
    .src_a(src_a), .src_b(src_b), .dst(dst), .wr_cmp(wr_cmp),
    .imm(imm), .illegal(illegal)
  );

  function automatic bit [4:0] mp(bit [2:0] c);
    if (c == 0) return 5'd16;
    if (c == 1) return 5'd17;
    return {2'b00, c};
  endfunction

  // expected bundle {valid, illegal, class, alu, a, b, d, wrcmp, imm}
  function automatic bit [40:0] model(bit pv, bit [10:0] p, bit v, bit [15:0] h);
    bit val = 0, ill = 0, wc = 0;
    bit [2:0] cls = 0;
    bit [3:0] alu = 15;
    bit [4:0] a = 0, b = 0, d = 0;
    bit [15:0] im = 0;
    if (v && h[15:11] != 5'b11110) begin
      val = 1;
      if (h[15:11] == 5'b11100) begin
        cls = 1; a = mp(h[10:8]); b = mp(h[7:5]); d = mp(h[4:2]);
        alu = (h[1:0] == 1) ? 4'd0 : (h[1:0] == 3) ? 4'd1 : (h[1:0] == 0) ? 4'd2 : 4'd3;
      end else if (h[15:11] == 5'b11101) begin
        cls = 2; a = mp(h[10:8]); b = mp(h[7:5]); d = mp(h[10:8]);
        case (h[4:0])
          5'd2:  begin alu = 4; d = 24; wc = 1; end
          5'd3:  begin alu = 5; d = 24; wc = 1; end
          5'd11: begin alu = 6; a = 0; end
          5'd12: alu = 7;
          5'd13: alu = 8;
          5'd14: alu = 9;
          5'd15: begin alu = 10; a = 0; end
          default: begin cls = 0; a = 0; b = 0; d = 0; end
        endcase
      end else if (h[15:11] == 5'b00110) begin
        cls = 3; a = mp(h[7:5]); d = mp(h[10:8]);
        alu = (h[1:0] == 0) ? 4'd11 : (h[1:0] == 2) ? 4'd12 : (h[1:0] == 3) ? 4'd13 : 4'd14;
        if (pv) im = {10'd0, (alu == 14) ? p[5] : 1'b0, p[10:6]};
        else    im = {13'd0, h[4:2]};
      end else if (h[15:11] == 5'b01110) begin
        cls = 4; alu = 9; a = mp(h[10:8]); d = 24; wc = 1;
        if (pv) im = {p[4:0], p[10:5], h[4:0]};
        else    im = {8'd0, h[7:0]};
      end
      if (pv && cls != 3 && cls != 4) begin
        ill = 1; cls = 0; alu = 15; a = 0; b = 0; d = 0; wc = 0; im = 0;
      end
    end
    return {val, ill, cls, alu, a, b, d, wc, im};
  endfunction

  task automatic step(bit v, bit [15:0] h, string tag);
    bit [40:0] exp_b, act_b;
    @(negedge clk);
    hw_valid = v; hw_data = h;
    #1;
    exp_b = model(m_pv, m_pay, v, h);
    act_b = {op_valid, illegal, op_class, alu_op, src_a, src_b, dst, wr_cmp, imm};
    n_run++;
    if (act_b !== exp_b) begin
      n_fail++;
      $display("FAIL %s hw=%h act=%h exp=%h", tag, h, act_b, exp_b);
    end
    @(posedge clk);
    if (rst_n && v) begin
      m_pv = (h[15:11] == 5'b11110);
      if (m_pv) m_pay = h[10:0];
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 0; hw_valid = 0;
    m_pv = 0;
    @(negedge clk);
    @(negedge clk);
    rst_n = 1;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    do_reset();
    step(0, 16'h0000, "R2 reset idle");
    // three-register, all function codes and register translation (R3, R9)
    step(1, {5'b11100, 3'd0, 3'd1, 3'd7, 2'b01}, "R3 add / R9 map");
    step(1, {5'b11100, 3'd2, 3'd3, 3'd4, 2'b11}, "R3 sub");
    step(1, {5'b11100, 3'd5, 3'd6, 3'd0, 2'b00}, "R3 dadd");
    step(1, {5'b11100, 3'd1, 3'd0, 3'd1, 2'b10}, "R9 dsub map");
    // register-register (R4, R5)
    step(1, {5'b11101, 3'd3, 3'd4, 5'b00010}, "R5 slt");
    step(1, {5'b11101, 3'd0, 3'd1, 5'b00011}, "R5 sltu");
    step(1, {5'b11101, 3'd2, 3'd5, 5'b01011}, "R4 neg");
    step(1, {5'b11101, 3'd6, 3'd7, 5'b01100}, "R4 and");
    step(1, {5'b11101, 3'd6, 3'd7, 5'b01101}, "R4 or");
    step(1, {5'b11101, 3'd6, 3'd7, 5'b01110}, "R4 xor");
    step(1, {5'b11101, 3'd1, 3'd2, 5'b01111}, "R4 not");
    step(1, {5'b11101, 3'd1, 3'd2, 5'b11000}, "R4 unknown function");
    // shifts short and extended (R6, R7)
    step(1, {5'b00110, 3'd4, 3'd5, 3'd7, 2'b00}, "R6 sll short");
    step(1, {5'b00110, 3'd4, 3'd5, 3'd3, 2'b11}, "R6 sra short");
    step(1, {5'b11110, 5'b10110, 1'b1, 5'b00000}, "R1 prefix");
    step(1, {5'b00110, 3'd2, 3'd3, 3'd0, 2'b01}, "R7 dsll six-bit amount");
    step(1, {5'b11110, 5'b11111, 1'b1, 5'b00000}, "R1 prefix");
    step(1, {5'b00110, 3'd2, 3'd3, 3'd0, 2'b10}, "R7 srl bit5 dropped");
    // compare immediate (R8)
    step(1, {5'b01110, 3'd3, 8'hA5}, "R8 cmpi short");
    step(1, {5'b11110, 6'b101010, 5'b10011}, "R1 prefix");
    step(0, 16'hFFFF, "R1 gap keeps prefix");
    step(0, 16'h0000, "R1 gap keeps prefix");
    step(1, {5'b01110, 3'd7, 3'b000, 5'b01101}, "R8 cmpi extended");
    step(1, {5'b01110, 3'd7, 8'hFF}, "R2 prefix consumed");
    // illegal and replacement (R10, R11)
    step(1, {5'b11110, 11'h7FF}, "R1 prefix");
    step(1, {5'b11100, 3'd1, 3'd2, 3'd3, 2'b01}, "R10 prefix before rrr");
    step(1, {5'b11110, 11'h123}, "R1 prefix");
    step(1, {5'b00000, 11'h123}, "R10 prefix before unknown");
    step(1, {5'b00000, 11'h123}, "R10 unknown without prefix");
    step(1, {5'b11110, 11'h000}, "R11 first prefix");
    step(1, {5'b11110, 6'b110011, 5'b01010}, "R11 second prefix");
    step(1, {5'b01110, 3'd2, 3'd0, 5'b00001}, "R11 newer prefix used");
    step(1, {5'b11110, 11'h7FF}, "R1 prefix");
    do_reset();
    step(1, {5'b01110, 3'd2, 8'h12}, "R11 reset drops prefix");
    // random stream
    for (int i = 0; i < 4000; i++) begin
      bit [15:0] h;
      bit [2:0] pick;
      bit [4:0] maj;
      pick = 3'($urandom_range(0, 6));
      case (pick)
        3'd0, 3'd1: maj = 5'b11110;
        3'd2: maj = 5'b11100;
        3'd3: maj = 5'b11101;
        3'd4: maj = 5'b00110;
        3'd5: maj = 5'b01110;
        default: maj = 5'($urandom);
      endcase
      h = {maj, 11'($urandom)};
      step(($urandom_range(0, 7) != 0), h, "R2 random stream");
    end
    done = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule